// File: doc/BRIEF.md
# Return-Address Shadow Stack Unit

This unit keeps a second, protected stack that holds nothing but return addresses. Each call event pushes the return address into an internal storage array. Each return event pops the top entry and compares it against the return address that the ordinary stack supplies. When the two differ, the unit reports a control-protection fault. Ordinary stores have no path into the storage. Only call and return events and a small set of management commands can change it.

The management commands let software move the shadow stack pointer forward by a count, read the pointer, and write an entry when it holds privilege. Software can also switch between shadow stacks. A restore command accepts a new stack only if a well-formed restore token sits at the addressed slot. The command then overwrites that token with a previous-pointer token. A later save-previous command follows the previous-pointer token back to the old stack and leaves a fresh restore token there. All stacks share one storage region that grows downward in 8-byte steps.

Commands arrive on a valid/ready stream. Each accepted command yields exactly one registered response on a second valid/ready stream in the following cycle. The command side is ready whenever the response slot is empty or being drained (`cmd_ready = !rsp_valid || rsp_ready`). A response that is not taken stays unchanged, and the command side stalls behind it.

Top module: `shstk_guard`

## Requirements
- R1: After reset the pointer equals the region top (base + 8*DEPTH), no response is pending, and the pointer always stays 8-byte aligned within [base, top].
- R2: `cmd_ready` equals `!rsp_valid || rsp_ready`. A command accepted at a clock edge produces its response in the next cycle. A response that is not consumed holds its data and fault flag, and no further command is accepted while it waits.
- R3: Command code 0 (call) lowers the pointer by 8 and stores `cmd_data` at the new pointer. If the pointer already equals the base, the command faults instead.
- R4: Command code 1 (return) compares the entry at the pointer with `cmd_data`. On a match it raises the pointer by 8, returns the entry in `rsp_data` and does not fault. On a mismatch it faults.
- R5: A return while the pointer equals the top (empty stack) faults.
- R6: Command code 2 (advance) adds 8 times `cmd_data[7:0]` to the pointer. If the sum would exceed the top, the command faults.
- R7: Command code 3 (read) returns the current pointer in `rsp_data` and changes nothing.
- R8: Command code 4 (entry write) stores `cmd_data` at `cmd_addr` only when `cmd_priv` is 1 and `cmd_addr` is an aligned address inside the region. Otherwise it faults and the storage is unchanged. The pointer does not move.
- R9: Command code 5 (restore) accepts a restore token at `cmd_addr`. A restore token has bit 0 = 1, bit 1 = 0, bit 2 = 0, and its value with the low three bits cleared equals `cmd_addr + 8`. On success the pointer becomes `cmd_addr` and that slot is overwritten with the previous pointer OR 3 (a previous-pointer token). Any other content, or an address outside the region, faults.
- R10: Command code 6 (save-previous) requires a previous-pointer token at the pointer, with bits 1:0 = 11 and bit 2 = 0. With P its value with the low bits cleared, it writes P OR 1 at P - 8 and raises the pointer by 8. A missing token, an empty stack, or a P - 8 outside the region faults.
- R11: A faulting command, including reserved code 7, sets `rsp_fault`, returns the unchanged pointer in `rsp_data`, and leaves pointer and storage unchanged. Non-faulting commands other than return report the new pointer in `rsp_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command accepted at this edge when valid |
| cmd_op | input | 3 | Command code (0 call … 6 save-previous, 7 reserved) |
| cmd_addr | input | WORD_W | Slot address for entry write and restore |
| cmd_data | input | WORD_W | Return address, write data, or advance count in [7:0] |
| cmd_priv | input | 1 | Privilege for entry write |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response consumed at this edge when valid |
| rsp_fault | output | 1 | Control-protection fault for this command |
| rsp_data | output | WORD_W | Pointer value, or popped entry for a good return |

## Verification
The bench builds the unit with DEPTH = 8 and the region based at 0x2000, so the top is 0x2040. With these values the full-stack fault needs only eight calls, and the advance command can reach the region top in one step. The restore and save-previous round trip between two stacks also fits inside the small region, next to the edge addresses just below the base and at the top. Back-pressure is exercised by holding `rsp_ready` low while a second command waits.

// File: rtl/shstk_pkg.sv
package shstk_pkg;
  typedef enum logic [2:0] {
    OP_CALL  = 3'd0,
    OP_RET   = 3'd1,
    OP_ADV   = 3'd2,
    OP_READ  = 3'd3,
    OP_WRITE = 3'd4,
    OP_RSTOR = 3'd5,
    OP_SAVE  = 3'd6,
    OP_RSV   = 3'd7
  } shstk_op_e;

  localparam int unsigned SLOT_BYTES = 8;
endpackage

// File: rtl/shstk_mem.sv
module shstk_mem #(
  parameter int unsigned DEPTH  = 32,
  parameter int unsigned WORD_W = 64,
  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  widx,
  input  logic [WORD_W-1:0] wdata,
  input  logic [IDX_W-1:0]  ridx,
  output logic [WORD_W-1:0] rdata
);
  logic [WORD_W-1:0] slots [DEPTH];

  always_ff @(posedge clk) begin
    if (we && (32'(widx) < DEPTH)) slots[widx] <= wdata;
  end

  always_comb begin
    if (32'(ridx) < DEPTH) rdata = slots[ridx];
    else                   rdata = '0;
  end
endmodule

// File: rtl/shstk_tokchk.sv
module shstk_tokchk #(
  parameter int unsigned WORD_W = 64
) (
  input  logic [WORD_W-1:0] tok,
  input  logic [WORD_W-1:0] expect_ptr,
  output logic              is_restore,
  output logic              is_prev,
  output logic [WORD_W-1:0] ptr
);
  always_comb begin
    ptr        = {tok[WORD_W-1:3], 3'b000};
    is_restore = tok[0] && !tok[1] && !tok[2] && (ptr == expect_ptr);
    is_prev    = tok[0] &&  tok[1] && !tok[2];
  end
endmodule

// File: rtl/shstk_guard.sv
module shstk_guard
  import shstk_pkg::*;
#(
  parameter int unsigned       DEPTH     = 32,
  parameter int unsigned       WORD_W    = 64,
  parameter logic [WORD_W-1:0] BASE_ADDR = 'h1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [2:0]        cmd_op,
  input  logic [WORD_W-1:0] cmd_addr,
  input  logic [WORD_W-1:0] cmd_data,
  input  logic              cmd_priv,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_fault,
  output logic [WORD_W-1:0] rsp_data
);
  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [WORD_W-1:0] STEP     = WORD_W'(SLOT_BYTES);
  localparam logic [WORD_W-1:0] TOP_ADDR = BASE_ADDR + WORD_W'(DEPTH * SLOT_BYTES);

  function automatic logic in_region(input logic [WORD_W-1:0] a);
    return (a >= BASE_ADDR) && (a < TOP_ADDR) && (a[2:0] == 3'b000);
  endfunction

  function automatic logic [IDX_W-1:0] slot_of(input logic [WORD_W-1:0] a);
    logic [WORD_W-1:0] off;
    off = a - BASE_ADDR;
    return off[IDX_W+2:3];
  endfunction

  shstk_op_e         op;
  logic              accept;
  logic [WORD_W-1:0] ssp, nxt_ssp;
  logic [WORD_W-1:0] rd_addr, rd_word;
  logic              flt, we;
  logic [WORD_W-1:0] wa, wd, out_data;
  logic              tok_restore, tok_prev;
  logic [WORD_W-1:0] tok_ptr, adv_sum;

  assign op        = shstk_op_e'(cmd_op);
  assign cmd_ready = !rsp_valid || rsp_ready;
  assign accept    = cmd_valid && cmd_ready;
  assign rd_addr   = (op == OP_RSTOR) ? cmd_addr : ssp;
  assign adv_sum   = ssp + {{(WORD_W-11){1'b0}}, cmd_data[7:0], 3'b000};

  shstk_mem #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_mem (
    .clk   (clk),
    .we    (accept && we),
    .widx  (slot_of(wa)),
    .wdata (wd),
    .ridx  (slot_of(rd_addr)),
    .rdata (rd_word)
  );

  shstk_tokchk #(.WORD_W(WORD_W)) u_tok (
    .tok        (rd_word),
    .expect_ptr (cmd_addr + STEP),
    .is_restore (tok_restore),
    .is_prev    (tok_prev),
    .ptr        (tok_ptr)
  );

  always_comb begin
    flt      = 1'b0;
    we       = 1'b0;
    wa       = ssp;
    wd       = cmd_data;
    nxt_ssp  = ssp;
    out_data = '0;
    unique case (op)
      OP_CALL: begin
        if (ssp == BASE_ADDR) flt = 1'b1;
        else begin
          nxt_ssp = ssp - STEP;
          we      = 1'b1;
          wa      = ssp - STEP;
        end
      end
      OP_RET: begin
        if (ssp == TOP_ADDR || rd_word != cmd_data) flt = 1'b1;
        else nxt_ssp = ssp + STEP;
      end
      OP_ADV: begin
        if (adv_sum > TOP_ADDR || adv_sum < ssp) flt = 1'b1;
        else nxt_ssp = adv_sum;
      end
      OP_READ: ;
      OP_WRITE: begin
        if (!cmd_priv || !in_region(cmd_addr)) flt = 1'b1;
        else begin
          we = 1'b1;
          wa = cmd_addr;
        end
      end
      OP_RSTOR: begin
        if (!in_region(cmd_addr) || !tok_restore) flt = 1'b1;
        else begin
          we      = 1'b1;
          wa      = cmd_addr;
          wd      = ssp | WORD_W'(3);
          nxt_ssp = cmd_addr;
        end
      end
      OP_SAVE: begin
        if (ssp == TOP_ADDR || !tok_prev || !in_region(tok_ptr - STEP)) flt = 1'b1;
        else begin
          we      = 1'b1;
          wa      = tok_ptr - STEP;
          wd      = tok_ptr | WORD_W'(1);
          nxt_ssp = ssp + STEP;
        end
      end
      default: flt = 1'b1;
    endcase
    if (flt)                 out_data = ssp;
    else if (op == OP_RET)   out_data = rd_word;
    else                     out_data = nxt_ssp;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ssp       <= TOP_ADDR;
      rsp_valid <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_data  <= '0;
    end else if (accept) begin
      rsp_valid <= 1'b1;
      rsp_fault <= flt;
      rsp_data  <= out_data;
      if (!flt) ssp <= nxt_ssp;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  assert_ssp_bounds_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (ssp[2:0] == 3'b000) && (ssp >= BASE_ADDR) && (ssp <= TOP_ADDR));

  assert_rsp_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data) && $stable(rsp_fault)));

  assert_call_push_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && op == OP_CALL && ssp != BASE_ADDR) |=> (!rsp_fault && ssp == $past(ssp) - STEP));

  assert_ret_mismatch_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && op == OP_RET && rd_word != cmd_data) |=> rsp_fault);

  assert_unpriv_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && op == OP_WRITE && !cmd_priv) |=> (rsp_fault && $stable(ssp)));

  assert_fault_freeze_R11: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (!rsp_fault || (ssp == $past(ssp) && rsp_data == $past(ssp))));
endmodule

// File: tb/shstk_guard_bench.sv
module shstk_guard_bench;
  localparam int unsigned W = 64;
  localparam logic [W-1:0] TOP = 64'h2040;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_priv = 1'b0, rsp_ready = 1'b1;
  logic [2:0] cmd_op = 3'd0;
  logic [W-1:0] cmd_addr = '0, cmd_data = '0;
  logic cmd_ready, rsp_valid, rsp_fault;
  logic [W-1:0] rsp_data;

  int checks = 0;
  int fails = 0;
  logic g_f;
  logic [W-1:0] g_d;

  always #5 clk = ~clk;

  shstk_guard #(.DEPTH(8), .WORD_W(W), .BASE_ADDR(64'h2000)) u_shstk_guard (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_data(cmd_data), .cmd_priv(cmd_priv),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_fault(rsp_fault), .rsp_data(rsp_data)
  );

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_cmd(input logic [2:0] op, input logic [W-1:0] a, input logic [W-1:0] d,
                        input logic p);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_data = d; cmd_priv = p;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R2 response one cycle after accept", {63'b0, rsp_valid}, 64'd1);
    g_f = rsp_fault;
    g_d = rsp_data;
  endtask

  task automatic expect_rsp(input string tag, input logic f, input logic [W-1:0] d);
    chk({tag, " fault"}, {63'b0, g_f}, {63'b0, f});
    chk({tag, " data"}, g_d, d);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R1 no response after reset", {63'b0, rsp_valid}, 64'd0);
    chk("R2 ready when idle", {63'b0, cmd_ready}, 64'd1);
    do_cmd(3'd3, '0, '0, 1'b0);
    expect_rsp("R1 R7 reset pointer", 1'b0, TOP);
  endtask

  task automatic t_call_ret;
    do_cmd(3'd0, '0, 64'h4000_1230, 1'b0); expect_rsp("R3 first call", 1'b0, 64'h2038);
    do_cmd(3'd0, '0, 64'h4000_5670, 1'b0); expect_rsp("R3 second call", 1'b0, 64'h2030);
    do_cmd(3'd3, '0, '0, 1'b0);            expect_rsp("R7 read", 1'b0, 64'h2030);
    do_cmd(3'd1, '0, 64'h4000_9990, 1'b0); expect_rsp("R4 R11 mismatch", 1'b1, 64'h2030);
    do_cmd(3'd1, '0, 64'h4000_5670, 1'b0); expect_rsp("R4 match B", 1'b0, 64'h4000_5670);
    do_cmd(3'd1, '0, 64'h4000_1230, 1'b0); expect_rsp("R4 match A", 1'b0, 64'h4000_1230);
    do_cmd(3'd3, '0, '0, 1'b0);            expect_rsp("R7 read empty", 1'b0, TOP);
  endtask

  task automatic t_empty;
    do_cmd(3'd1, '0, 64'h4000_1230, 1'b0); expect_rsp("R5 empty pop", 1'b1, TOP);
  endtask

  task automatic t_full_adv;
    for (int i = 0; i < 8; i++) begin
      do_cmd(3'd0, '0, 64'h5000_0000 + 64'(i * 16), 1'b0);
      expect_rsp("R3 fill", 1'b0, TOP - 64'((i + 1) * 8));
    end
    do_cmd(3'd0, '0, 64'h6000_0000, 1'b0); expect_rsp("R3 full fault", 1'b1, 64'h2000);
    do_cmd(3'd1, '0, 64'h5000_0070, 1'b0); expect_rsp("R4 pop after full", 1'b0, 64'h5000_0070);
    do_cmd(3'd2, '0, 64'h0000_0F07, 1'b0); expect_rsp("R6 advance to top", 1'b0, TOP);
    do_cmd(3'd2, '0, 64'd1, 1'b0);         expect_rsp("R6 advance past top", 1'b1, TOP);
    do_cmd(3'd2, '0, 64'd0, 1'b0);         expect_rsp("R6 advance zero", 1'b0, TOP);
  endtask

  task automatic t_write;
    do_cmd(3'd0, '0, 64'h7000_0010, 1'b0);      expect_rsp("R3 call X", 1'b0, 64'h2038);
    do_cmd(3'd4, 64'h2038, 64'h7000_0020, 1'b1); expect_rsp("R8 priv write", 1'b0, 64'h2038);
    do_cmd(3'd4, 64'h2038, 64'h7000_0030, 1'b0); expect_rsp("R8 unpriv write", 1'b1, 64'h2038);
    do_cmd(3'd4, 64'h2004, 64'h7000_0030, 1'b1); expect_rsp("R8 misaligned", 1'b1, 64'h2038);
    do_cmd(3'd4, TOP, 64'h7000_0030, 1'b1);      expect_rsp("R8 at top", 1'b1, 64'h2038);
    do_cmd(3'd4, 64'h1FF8, 64'h7000_0030, 1'b1); expect_rsp("R8 below base", 1'b1, 64'h2038);
    do_cmd(3'd1, '0, 64'h7000_0020, 1'b0);      expect_rsp("R8 written value pops", 1'b0, 64'h7000_0020);
  endtask

  task automatic t_switch;
    do_cmd(3'd0, '0, 64'h4000_1230, 1'b0);  expect_rsp("R3 call on old", 1'b0, 64'h2038);
    do_cmd(3'd4, 64'h2018, 64'h2021, 1'b1); expect_rsp("R8 plant token", 1'b0, 64'h2038);
    do_cmd(3'd5, 64'h2018, '0, 1'b0);       expect_rsp("R9 restore", 1'b0, 64'h2018);
    do_cmd(3'd6, '0, '0, 1'b0);             expect_rsp("R10 save-previous", 1'b0, 64'h2020);
    do_cmd(3'd5, 64'h2030, '0, 1'b0);       expect_rsp("R9 R10 restore old", 1'b0, 64'h2030);
    do_cmd(3'd6, '0, '0, 1'b0);             expect_rsp("R9 R10 save back", 1'b0, 64'h2038);
    do_cmd(3'd1, '0, 64'h4000_1230, 1'b0);  expect_rsp("R4 old stack intact", 1'b0, 64'h4000_1230);
    do_cmd(3'd4, 64'h2010, 64'h2029, 1'b1); expect_rsp("R8 bad pointer token", 1'b0, TOP);
    do_cmd(3'd5, 64'h2010, '0, 1'b0);       expect_rsp("R9 wrong pointer", 1'b1, TOP);
    do_cmd(3'd4, 64'h2010, 64'h201B, 1'b1); expect_rsp("R8 prev token", 1'b0, TOP);
    do_cmd(3'd5, 64'h2010, '0, 1'b0);       expect_rsp("R9 prev not restore", 1'b1, TOP);
    do_cmd(3'd4, 64'h2010, 64'h201D, 1'b1); expect_rsp("R8 bit2 token", 1'b0, TOP);
    do_cmd(3'd5, 64'h2010, '0, 1'b0);       expect_rsp("R9 bit2 set", 1'b1, TOP);
    do_cmd(3'd5, 64'h2040, '0, 1'b0);       expect_rsp("R9 outside region", 1'b1, TOP);
    do_cmd(3'd6, '0, '0, 1'b0);             expect_rsp("R10 empty", 1'b1, TOP);
    do_cmd(3'd0, '0, 64'h4000_1230, 1'b0);  expect_rsp("R3 call", 1'b0, 64'h2038);
    do_cmd(3'd6, '0, '0, 1'b0);             expect_rsp("R10 no token", 1'b1, 64'h2038);
    do_cmd(3'd7, '0, '0, 1'b1);             expect_rsp("R11 reserved", 1'b1, 64'h2038);
    do_cmd(3'd1, '0, 64'h4000_1230, 1'b0);  expect_rsp("R11 state kept", 1'b0, 64'h4000_1230);
  endtask

  task automatic t_backpressure;
    @(negedge clk);
    rsp_ready = 1'b0;
    cmd_valid = 1'b1; cmd_op = 3'd3; cmd_addr = '0; cmd_data = '0; cmd_priv = 1'b0;
    @(negedge clk);
    cmd_op = 3'd0; cmd_data = 64'h7700_0000;
    chk("R2 stalled valid", {63'b0, rsp_valid}, 64'd1);
    chk("R2 stalled not ready", {63'b0, cmd_ready}, 64'd0);
    chk("R2 stalled data", rsp_data, TOP);
    @(negedge clk);
    chk("R2 still held", {63'b0, rsp_valid}, 64'd1);
    chk("R2 data held", rsp_data, TOP);
    chk("R2 fault held", {63'b0, rsp_fault}, 64'd0);
    rsp_ready = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R2 R3 queued call", rsp_data, 64'h2038);
    do_cmd(3'd1, '0, 64'h7700_0000, 1'b0);
    expect_rsp("R4 cleanup", 1'b0, 64'h7700_0000);
  endtask

  task automatic finish_run;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_call_ret();
    t_empty();
    t_full_adv();
    t_write();
    t_switch();
    t_backpressure();
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule